// File: doc/BRIEF.md
# External I/O Bank Access Sequencer

This block runs read and write cycles to slow peripherals on an external bus that is split into several chip-select banks. A client hands it one access at a time over a valid/ready request port. Each access carries a bank number, a direction, an address and write data. The sequencer then drives a chip select for that bank, plus the read strobe (`oe_no`) or the write strobe (`we_no`), the address and the data bus. Each bank has its own 3-bit lengths for three phases: a setup phase where chip select is active but no strobe is active, a strobe phase, and a chip-select hold phase that follows the strobe.

The slow device can stretch the strobe in two ways. The first is an active-low wait line, which counts only for banks whose wait-enable bit is set. The second is an active-low transfer-ready line, which must be low for data to move. Both lines pass through two-flop synchronizers. A configuration register holds one wait-enable bit per bank and a hold-skip bit, and it resets to all zeros.

When hold-skip is set, the hold phase is dropped for a write after a write, a read after a read, or a read after a write, provided the two accesses go to the same bank with no idle cycle between them. A write that follows a read always keeps its hold phase, so the device has time to release the bus. The first access of a run also keeps its hold phase. A run starts after an idle gap or after a change of bank.

Top module: `extio_bank_seq`

## Requirements
- R1: After reset, every chip select, `oe_no` and `we_no` are high, `data_oe_o` and `done_o` are low, and `req_ready_o` is high. The configuration register is zero, so the wait line has no effect on any bank and every access keeps its full hold phase.
- R2: An accepted access asserts only the chip select `cs_no[bank]`, which is active low. Chip select stays low through setup, strobe and hold. The setup phase lasts the bank's setup length in cycles, with no strobe. `oe_no` is low for a read and `we_no` is low for a write, never both at once. The address, and the write data with `data_oe_o` high, stay steady while chip select is low.
- R3: The strobe lasts the bank's access length in cycles, and an access length of 0 gives a 1-cycle strobe.
- R4: When hold-skip is 0, every access, of any direction, keeps chip select low for exactly the bank's hold length after the strobe ends.
- R5: When hold-skip is 1, a back-to-back same-bank write→write, read→read or write→read access has no hold phase.
- R6: When hold-skip is 1, a read followed back-to-back by a write to the same bank still gets the full hold phase.
- R7: The first access after an idle cycle, and an access to a bank other than the previous one, always gets the full hold phase.
- R8: For a bank with its wait-enable bit set, a low wait line holds the strobe active, and the strobe ends only after the line returns high. Because of the synchronizer, the strobe stays active for the two cycles after the rising edge.
- R9: For a bank with its wait-enable bit clear, the wait line has no effect on the strobe length.
- R10: While the transfer-ready line is high, the strobe cannot complete, whatever the wait-enable setting.
- R11: A read samples `data_i` in the last strobe cycle. It presents that value on `rd_data_o` together with a one-cycle `done_o` pulse in the cycle right after the strobe. A write also pulses `done_o`.
- R12: `req_ready_o` is high only when the sequencer is idle or in the last cycle of an access. An access accepted in that last cycle starts with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write enable for the configuration register |
| cfg_wdata_i | input | NBANK+1 | Bit NBANK is hold-skip; bits NBANK-1..0 are the wait-enable bits, one per bank |
| tim_setup_i | input | NBANK*TW | Setup length for each bank, TW bits per bank, bank 0 in the low bits |
| tim_access_i | input | NBANK*TW | Strobe length for each bank (0 means 1) |
| tim_hold_i | input | NBANK*TW | Chip-select hold length for each bank |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted on a cycle where valid and ready are both high |
| req_bank_i | input | BW | Target bank |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Access address |
| req_wdata_i | input | DW | Write data |
| ext_wait_ni | input | 1 | Active-low wait line from the devices (asynchronous) |
| dev_rdy_ni | input | 1 | Active-low transfer-ready line (asynchronous) |
| cs_no | output | NBANK | Active-low chip selects, one per bank |
| oe_no | output | 1 | Active-low read strobe |
| we_no | output | 1 | Active-low write strobe |
| addr_o | output | AW | External address |
| data_o | output | DW | External write data |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| data_i | input | DW | External read data |
| done_o | output | 1 | One-cycle pulse after an access's strobe |
| rd_data_o | output | DW | Data captured by the last read |

## Verification
The bench runs back-to-back same-bank sequences with hold-skip off and then on, and measures the cycles during which chip select stays low after each strobe. A design that mixes up the direction pair would drop the hold on a read→write or keep it on a write→read. It also sends an access after an idle gap and after a bank change, where a design that forgets to restart the run would wrongly skip the first hold. The bench holds the wait line low on a wait-enabled bank, then on a bank without wait enable, and holds the ready line high. This shows whether a design ignores the enable, stretches the wrong bank, or ends the strobe before the synchronizer latency has passed. A zero access length and the read-data capture point are also checked, since an off-by-one counter would show up there as a strobe of the wrong length or stale data.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  parameter int unsigned EBS_TIM_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2,
    PH_HOLD   = 2'd3
  } ebs_phase_e;

endpackage

// File: rtl/ebs_sync2.sv
// Two-flop synchronizer for one asynchronous level input.
module ebs_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {2{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[1];

endmodule

// File: rtl/ebs_cfg_reg.sv
// Control word: a wait-enable bit per bank and a hold-skip bit.
module ebs_cfg_reg #(
  parameter int unsigned NBANK = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [NBANK:0]   wdata_i,
  output logic [NBANK-1:0] wait_en_o,
  output logic             hold_skip_o
);

  logic [NBANK:0] cfg_q;
  logic [NBANK:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign wait_en_o   = cfg_q[NBANK-1:0];
  assign hold_skip_o = cfg_q[NBANK];

endmodule

// File: rtl/ebs_hold_ctl.sv
// Tracks the current run of back-to-back accesses and picks the hold
// length for the access being accepted.
module ebs_hold_ctl #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned TW    = 3,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          release_i,
  input  logic [BW-1:0] bank_i,
  input  logic          write_i,
  input  logic          skip_en_i,
  input  logic [TW-1:0] tcoh_i,
  output logic [TW-1:0] hold_len_o
);

  logic          run_q, run_d;
  logic [BW-1:0] bank_q, bank_d;
  logic          wr_q, wr_d;
  logic          same_run;
  logic          rd_then_wr;
  logic          skip;

  always_comb begin
    same_run   = run_q && (bank_q == bank_i);
    rd_then_wr = !wr_q && write_i;
    skip       = skip_en_i && same_run && !rd_then_wr;
    hold_len_o = skip ? '0 : tcoh_i;
  end

  always_comb begin
    run_d  = run_q;
    bank_d = bank_q;
    wr_d   = wr_q;
    if (accept_i) begin
      run_d  = 1'b1;
      bank_d = bank_i;
      wr_d   = write_i;
    end else if (release_i) begin
      run_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      bank_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      run_q  <= run_d;
      bank_q <= bank_d;
      wr_q   <= wr_d;
    end
  end

endmodule

// File: rtl/extio_bank_seq.sv
module extio_bank_seq #(
  parameter int unsigned NBANK = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned TW    = ebs_pkg::EBS_TIM_W,
  localparam int unsigned BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [NBANK:0]      cfg_wdata_i,
  input  logic [NBANK*TW-1:0] tim_setup_i,
  input  logic [NBANK*TW-1:0] tim_access_i,
  input  logic [NBANK*TW-1:0] tim_hold_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [BW-1:0]       req_bank_i,
  input  logic                req_write_i,
  input  logic [AW-1:0]       req_addr_i,
  input  logic [DW-1:0]       req_wdata_i,
  input  logic                ext_wait_ni,
  input  logic                dev_rdy_ni,
  output logic [NBANK-1:0]    cs_no,
  output logic                oe_no,
  output logic                we_no,
  output logic [AW-1:0]       addr_o,
  output logic [DW-1:0]       data_o,
  output logic                data_oe_o,
  input  logic [DW-1:0]       data_i,
  output logic                done_o,
  output logic [DW-1:0]       rd_data_o
);

  import ebs_pkg::*;

  function automatic logic [TW-1:0] eff_len(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  // Per-bank timing fields
  logic [TW-1:0] setup_a  [NBANK];
  logic [TW-1:0] access_a [NBANK];
  logic [TW-1:0] hold_a   [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_tim
    assign setup_a[g]  = tim_setup_i[g*TW +: TW];
    assign access_a[g] = tim_access_i[g*TW +: TW];
    assign hold_a[g]   = tim_hold_i[g*TW +: TW];
  end

  // Configuration and synchronized device lines
  logic [NBANK-1:0] wait_en;
  logic             hold_skip;
  logic             wait_s_n;
  logic             rdy_s_n;

  ebs_cfg_reg #(.NBANK(NBANK)) cfg_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .wdata_i     (cfg_wdata_i),
    .wait_en_o   (wait_en),
    .hold_skip_o (hold_skip)
  );

  ebs_sync2 #(.RST_VAL(1'b1)) wait_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_wait_ni),
    .q_o    (wait_s_n)
  );

  ebs_sync2 #(.RST_VAL(1'b0)) rdy_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dev_rdy_ni),
    .q_o    (rdy_s_n)
  );

  // State
  ebs_phase_e    phase_q, phase_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] bank_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [TW-1:0] hold_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;

  logic          accept;
  logic          stall;
  logic          acc_end;
  logic          last_cycle;
  logic          release_run;
  logic [TW-1:0] new_hold;
  logic [TW-1:0] new_setup;
  logic [TW-1:0] new_access;
  logic [TW-1:0] cur_access;

  always_comb begin
    stall       = (wait_en[bank_q] && !wait_s_n) || rdy_s_n;
    acc_end     = (phase_q == PH_ACCESS) && (cnt_q == '0) && !stall;
    last_cycle  = (acc_end && (hold_q == '0)) ||
                  ((phase_q == PH_HOLD) && (cnt_q == '0));
    req_ready_o = (phase_q == PH_IDLE) || last_cycle;
    accept      = req_valid_i && req_ready_o;
    release_run = req_ready_o && !req_valid_i;
    new_setup   = setup_a[req_bank_i];
    new_access  = eff_len(access_a[req_bank_i]);
    cur_access  = eff_len(access_a[bank_q]);
  end

  ebs_hold_ctl #(.NBANK(NBANK), .TW(TW)) hold_ctl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .release_i  (release_run),
    .bank_i     (req_bank_i),
    .write_i    (req_write_i),
    .skip_en_i  (hold_skip),
    .tcoh_i     (hold_a[req_bank_i]),
    .hold_len_o (new_hold)
  );

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACCESS;
          cnt_d   = cur_access - TW'(1);
        end else begin
          cnt_d   = cnt_q - TW'(1);
        end
      end
      PH_ACCESS: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - TW'(1);
        end else if (!stall) begin
          if (hold_q != '0) begin
            phase_d = PH_HOLD;
            cnt_d   = hold_q - TW'(1);
          end else begin
            phase_d = PH_IDLE;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d   = cnt_q - TW'(1);
        end
      end
      default: begin
        phase_d = PH_IDLE;
      end
    endcase
    if (accept) begin
      if (new_setup != '0) begin
        phase_d = PH_SETUP;
        cnt_d   = new_setup - TW'(1);
      end else begin
        phase_d = PH_ACCESS;
        cnt_d   = new_access - TW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= acc_end;
    end
  end

  // Access attributes, loaded on acceptance
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
    end else if (accept) begin
      bank_q  <= req_bank_i;
      wr_q    <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      hold_q  <= new_hold;
    end
  end

  // Read capture on the last strobe cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (acc_end && !wr_q) begin
      rdata_q <= data_i;
    end
  end

  // Pin outputs
  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign cs_no[b] = !((phase_q != PH_IDLE) && (bank_q == BW'(b)));
  end

  assign oe_no     = !((phase_q == PH_ACCESS) && !wr_q);
  assign we_no     = !((phase_q == PH_ACCESS) && wr_q);
  assign addr_o    = addr_q;
  assign data_o    = wdata_q;
  assign data_oe_o = (phase_q != PH_IDLE) && wr_q;
  assign done_o    = done_q;
  assign rd_data_o = rdata_q;

endmodule

// File: rtl/extio_bank_seq_chk.sv
module extio_bank_seq_chk #(
  parameter int unsigned NBANK = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NBANK-1:0] cs_no,
  input logic             oe_no,
  input logic             we_no,
  input logic             data_oe_o,
  input logic             req_ready_o,
  input logic             done_o
);

  logic strobe;
  assign strobe = !oe_no || !we_no;

  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !we_no));

  // R2
  strobe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |-> !(&cs_no));

  // R2
  drive_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !(&cs_no));

  // R12
  idle_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_no) |-> req_ready_o);

  // R11
  done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(strobe));

endmodule

bind extio_bank_seq extio_bank_seq_chk #(.NBANK(NBANK)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_no       (cs_no),
  .oe_no       (oe_no),
  .we_no       (we_no),
  .data_oe_o   (data_oe_o),
  .req_ready_o (req_ready_o),
  .done_o      (done_o)
);

// File: tb/extio_bank_seq_tb_top.sv
`timescale 1ns/1ps
module extio_bank_seq_tb_top;

  localparam int NB = 4;
  localparam int TW = 3;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [NB:0]   cfg_wdata;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_bank;
  logic          req_write;
  logic [15:0]   req_addr;
  logic [15:0]   req_wdata;
  logic          ext_wait_n;
  logic          dev_rdy_n;
  logic [NB-1:0] cs_n;
  logic          oe_n, we_n, data_oe, done;
  logic [15:0]   addr, wdat, rdat, bus_in;

  // Bank timing: setup {1,2,1,1}, access {2,0,3,1}, hold {3,2,0,1}; bank 0 in low bits
  localparam logic [NB*TW-1:0] SETUP_V  = {3'd1, 3'd1, 3'd2, 3'd1};
  localparam logic [NB*TW-1:0] ACCESS_V = {3'd1, 3'd3, 3'd0, 3'd2};
  localparam logic [NB*TW-1:0] HOLD_V   = {3'd1, 3'd0, 3'd2, 3'd3};
  int su [NB] = '{1, 2, 1, 1};
  int ac [NB] = '{2, 1, 3, 1};
  int ho [NB] = '{3, 2, 0, 1};

  assign bus_in = addr ^ 16'h5A3C;

  extio_bank_seq #(.NBANK(NB), .AW(16), .DW(16), .TW(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .tim_setup_i(SETUP_V), .tim_access_i(ACCESS_V), .tim_hold_i(HOLD_V),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_bank_i(req_bank),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .ext_wait_ni(ext_wait_n), .dev_rdy_ni(dev_rdy_n), .cs_no(cs_n),
    .oe_no(oe_n), .we_no(we_n), .addr_o(addr), .data_o(wdat),
    .data_oe_o(data_oe), .data_i(bus_in), .done_o(done), .rd_data_o(rdat)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct {
    int          bank;
    bit          wr;
    logic [15:0] a;
    logic [15:0] d;
    int          slen;
    bit          minf;
    int          hold;
    int          setup;
    int          req;
  } item_t;

  item_t q[$];

  // Driver-side model of the run state
  bit skip_m = 1'b0;
  bit run_m  = 1'b0;
  int last_b = 0;
  bit last_w = 1'b0;

  task automatic send(input int b, input bit w, input logic [15:0] a,
                      input logic [15:0] d, input int req, input bit minf,
                      input int smin);
    item_t it;
    it.bank  = b;
    it.wr    = w;
    it.a     = a;
    it.d     = d;
    it.minf  = minf;
    it.slen  = minf ? smin : ac[b];
    it.setup = su[b];
    it.req   = req;
    it.hold  = ho[b];
    if (skip_m && run_m && last_b == b && !(!last_w && w)) it.hold = 0;
    run_m  = 1'b1;
    last_b = b;
    last_w = w;
    q.push_back(it);
    @(negedge clk);
    req_valid = 1'b1;
    req_bank  = 2'(b);
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic idle_gap();
    @(negedge clk);
    req_valid = 1'b0;
    while (!(&cs_n)) @(negedge clk);
    run_m = 1'b0;
  endtask

  // Monitor: measures strobe length and post-strobe chip-select time
  item_t cur;
  bit    in_strobe = 1'b0;
  bit    gap_on    = 1'b0;
  int    slen_c    = 0;
  int    gap_c     = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit stb = !oe_n || !we_n;
      if (stb && !in_strobe) begin
        if (q.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", 1, 0);
        end else begin
          if (gap_on) begin
            chk(gap_c == cur.hold + q[0].setup, $sformatf("R%0d hold+setup gap", cur.req),
                gap_c, cur.hold + q[0].setup);
            gap_on = 1'b0;
          end
          cur = q.pop_front();
          chk(cs_n == ~(4'b1 << cur.bank), "R2 chip select", cs_n, ~(4'b1 << cur.bank));
          chk(we_n == !cur.wr && oe_n == cur.wr, "R2 strobe type", {oe_n, we_n}, {cur.wr, !cur.wr});
          chk(addr == cur.a, "R2 address", addr, cur.a);
          if (cur.wr) chk(wdat == cur.d && data_oe, "R2 write data", wdat, cur.d);
          in_strobe = 1'b1;
          slen_c = 0;
        end
      end
      if (stb) slen_c++;
      if (!stb && in_strobe) begin
        in_strobe = 1'b0;
        if (cur.minf) chk(slen_c >= cur.slen, $sformatf("R%0d strobe length min", cur.req), slen_c, cur.slen);
        else          chk(slen_c == cur.slen, $sformatf("R%0d strobe length", cur.req), slen_c, cur.slen);
        gap_on = 1'b1;
        gap_c  = 0;
      end
      if (!stb && done && !cur.wr)
        chk(rdat == (cur.a ^ 16'h5A3C), "R11 read data", rdat, cur.a ^ 16'h5A3C);
      if (!stb && gap_on) begin
        if (!cs_n[cur.bank]) begin
          gap_c++;
        end else begin
          chk(gap_c == cur.hold, $sformatf("R%0d hold length", cur.req), gap_c, cur.hold);
          gap_on = 1'b0;
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req_valid = 1'b0;
    req_bank = '0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    ext_wait_n = 1'b1; dev_rdy_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 4'hF && oe_n && we_n, "R1 pins idle", {cs_n, oe_n, we_n}, 6'h3F);
    chk(req_ready && !done && !data_oe, "R1 ready/done", {req_ready, done, data_oe}, 3'b100);

    // R1: zero config, wait line low must not stretch bank 0
    ext_wait_n = 1'b0;
    send(0, 1, 16'h1000, 16'hBEEF, 1, 0, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R12 busy not ready", req_ready, 0);
    idle_gap();
    ext_wait_n = 1'b1;

    // R4: hold-skip off, back-to-back same bank, every hold kept
    send(0, 1, 16'h1001, 16'h0011, 4, 0, 0);
    send(0, 1, 16'h1002, 16'h0022, 4, 0, 0);
    send(0, 0, 16'h1003, 16'h0000, 4, 0, 0);
    send(0, 0, 16'h1004, 16'h0000, 4, 0, 0);
    send(0, 1, 16'h1005, 16'h0055, 4, 0, 0);
    idle_gap();

    // Enable hold-skip and wait on bank 1
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 5'b1_0010;
    @(negedge clk);
    cfg_we = 1'b0;
    skip_m = 1'b1;

    // R5 / R6 / R7: first keeps hold, W-W, W-R, R-R skip, R-W keeps
    send(0, 1, 16'h2000, 16'hA001, 7, 0, 0);
    send(0, 1, 16'h2001, 16'hA002, 5, 0, 0);
    send(0, 0, 16'h2002, 16'h0000, 5, 0, 0);
    send(0, 0, 16'h2003, 16'h0000, 5, 0, 0);
    send(0, 1, 16'h2004, 16'hA005, 6, 0, 0);
    send(0, 1, 16'h2005, 16'hA006, 5, 0, 0);
    idle_gap();

    // R7: bank change restarts the run
    send(3, 1, 16'h3000, 16'hC001, 7, 0, 0);
    send(0, 1, 16'h3001, 16'hC002, 7, 0, 0);
    send(0, 1, 16'h3002, 16'hC003, 5, 0, 0);
    idle_gap();

    // R3: zero access length on bank 1 gives a one-cycle strobe
    send(1, 0, 16'h4000, 16'h0000, 3, 0, 0);
    idle_gap();

    // R8: wait-enabled bank 1 held by the wait line
    ext_wait_n = 1'b0;
    send(1, 0, 16'h4100, 16'h0000, 8, 1, 8);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (11) @(negedge clk);
    chk(!oe_n, "R8 strobe stretched", oe_n, 0);
    ext_wait_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!oe_n, "R8 synchronizer latency", oe_n, 0);
    @(negedge clk);
    chk(oe_n, "R8 strobe released", oe_n, 1);
    idle_gap();

    // R9: bank 2 without wait enable ignores the wait line
    ext_wait_n = 1'b0;
    send(2, 0, 16'h5000, 16'h0000, 9, 0, 0);
    idle_gap();
    ext_wait_n = 1'b1;

    // R10: transfer-ready high stalls bank 2
    dev_rdy_n = 1'b1;
    send(2, 1, 16'h5100, 16'h7777, 10, 1, 6);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(!we_n, "R10 strobe held by ready", we_n, 0);
    dev_rdy_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!we_n, "R10 synchronizer latency", we_n, 0);
    @(negedge clk);
    chk(we_n, "R10 strobe released", we_n, 1);
    idle_gap();

    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R2 all accesses seen", q.size(), 0);
    summary();
  end

endmodule